// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects fifteen interrupt requests for an 8-bit microcontroller core, chooses one, and presents it to the core as a 4-bit source index. Four of the sources are edge flags: two external edges and two timer overflows. The hardware clears each of these when the core acknowledges it. Five asynchronous port pins pass through a synchronizer and a per-pin polarity select. They set latched flags, and so do four peripheral event inputs. Only a software clear pulse drops these flags. Two further sources, a serial-bus request and a tone-detector request, are plain levels owned by their peripherals.

Every source has its own enable bit and its own priority bit. A global enable gates all of them. The controller holds a two-entry level stack. A high-priority request may interrupt a low-priority service routine, and nothing interrupts a high-priority routine. A return pulse from the core unwinds the most recent level. A request is raised with its index and level and is held unchanged until the core acknowledges it.

Top module: `prio_intc`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `irq_req` is 0, `irq_vec` is 0, `irq_hi` is 0, `act_lvl` is 2'b00 and `pend` is all zero.
- R2: Pin n (n=0..4) is pending as source 4+n. Its flag sets on the third rising edge after `pin_raw[n]` starts to equal `pin_pol[n]`. A `pin_pol` bit of 1 selects active-high and 0 selects active-low.
- R3: Sources 4..12 are latched flags. They are cleared only by `sw_clr` (bits 0..4 for pins, bits 5..8 for events 9..12). A clear pulse makes the flag 0 in the next cycle. If the source is still active, the flag returns to 1 one cycle later.
- R4: Sources 0..3 set on a `hw_set` pulse. Each one is cleared by the acknowledge of a request that carries its own index, and by nothing else. Sources 13 and 14 follow `lvl_req` with one cycle of delay.
- R5: A source can be requested only when `en_global` and its `en_src` bit are both 1.
- R6: Among the eligible sources, the ones with their `prio_hi` bit at 1 win. Within one level, the lowest index wins. `irq_hi` reports the level of the winner.
- R7: Once `irq_req` rises, `irq_vec` and `irq_hi` stay constant until `irq_ack` is seen. `irq_req` is 0 in the cycle after the acknowledge.
- R8: `act_lvl` bit 0 marks low-priority service and bit 1 marks high-priority service. An acknowledge sets the bit that matches `irq_hi`. `reti` clears bit 1 if it is set, and otherwise clears bit 0. While bit 1 is set, no request is raised. While bit 0 alone is set, only high-priority requests are raised.
- R9: An `irq_ack` while `irq_req` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_set | input | 4 | Set pulses for sources 0..3 |
| pin_raw | input | 5 | Asynchronous pin inputs (sources 4..8) |
| pin_pol | input | 5 | Active level per pin |
| evt_in | input | 4 | Peripheral event inputs (sources 9..12) |
| lvl_req | input | 2 | Level requests (sources 13, 14) |
| sw_clr | input | 9 | Software clear pulses for latched flags |
| en_global | input | 1 | Global enable |
| en_src | input | 15 | Per-source enables |
| prio_hi | input | 15 | Per-source high-priority select |
| irq_ack | input | 1 | Core acknowledge pulse |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Request to core |
| irq_vec | output | 4 | Requested source index |
| irq_hi | output | 1 | Requested level is high |
| act_lvl | output | 2 | Levels in service {high, low} |
| pend | output | 15 | Pending flags per source |

## Verification
Two edge flags raised together show whether the index order is kept within a level, and the same pair with one of them promoted shows whether the level outranks the index. Pin activity is applied under both polarities. A clear pulse is sent while a pin is still active, which tells the one-cycle drop and re-set apart from a clear that sticks. Requests are then stacked low, high, low with returns in between, which tells correct preemption and unwinding apart from a stack that blocks or allows the wrong level.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int N_HW_P  = 4;
  localparam int N_PIN_P = 5;
  localparam int N_EVT_P = 4;
  localparam int N_LVL_P = 2;
  localparam int SYNC_P  = 2;
  localparam int LV_LO   = 0;
  localparam int LV_HI   = 1;
endpackage

// File: rtl/intc_src_flags.sv
module intc_src_flags #(
  parameter int N_HW  = 4,
  parameter int N_PIN = 5,
  parameter int N_EVT = 4,
  parameter int N_LVL = 2,
  parameter int SYNC  = 2,
  localparam int N_SW  = N_PIN + N_EVT,
  localparam int N_SRC = N_HW + N_SW + N_LVL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_HW-1:0]  hw_set,
  input  logic [N_HW-1:0]  hw_clr,
  input  logic [N_PIN-1:0] pin_raw,
  input  logic [N_PIN-1:0] pin_pol,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [N_LVL-1:0] lvl_in,
  input  logic [N_SW-1:0]  sw_clr,
  output logic [N_SRC-1:0] pend
);
  logic [N_PIN-1:0] sync_q [SYNC];
  logic [N_HW-1:0]  hw_f;
  logic [N_SW-1:0]  sw_f;
  logic [N_SW-1:0]  sw_act;
  logic [N_LVL-1:0] lvl_q;

  genvar k;
  generate
    for (k = 0; k < SYNC; k++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[k] <= '0;
        else if (k == 0) sync_q[k] <= pin_raw;
        else sync_q[k] <= sync_q[(k == 0) ? 0 : k - 1];
      end
    end
  endgenerate

  assign sw_act = {evt_in, ~(sync_q[SYNC-1] ^ pin_pol)};

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_f  <= '0;
      sw_f  <= '0;
      lvl_q <= '0;
    end else begin
      for (int i = 0; i < N_HW; i++)
        if (hw_set[i]) hw_f[i] <= 1'b1;
        else if (hw_clr[i]) hw_f[i] <= 1'b0;
      for (int i = 0; i < N_SW; i++)
        if (sw_clr[i]) sw_f[i] <= 1'b0;
        else if (sw_act[i]) sw_f[i] <= 1'b1;
      lvl_q <= lvl_in;
    end
  end

  assign pend = {lvl_q, sw_f, hw_f};

  generate
    for (k = 0; k < N_SW; k++) begin : g_chk_sw
      p_swclr_r3: assert property (@(posedge clk) disable iff (rst)
        sw_clr[k] |=> !sw_f[k]);
    end
    for (k = 0; k < N_HW; k++) begin : g_chk_hw
      p_hwset_r4: assert property (@(posedge clk) disable iff (rst)
        hw_set[k] |=> hw_f[k]);
    end
  endgenerate
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int N_SRC = 15,
  localparam int VW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] en_src,
  input  logic [N_SRC-1:0] prio_hi,
  input  logic             en_global,
  input  logic             allow_hi,
  input  logic             allow_lo,
  output logic             found,
  output logic [VW-1:0]    idx,
  output logic             hi
);
  logic [N_SRC-1:0] cand_hi, cand_lo;

  assign cand_hi = (allow_hi && en_global) ? (pend & en_src & prio_hi)  : '0;
  assign cand_lo = (allow_lo && en_global) ? (pend & en_src & ~prio_hi) : '0;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    hi    = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (cand_lo[i]) begin
        found = 1'b1;
        idx   = VW'(i);
      end
    for (int i = N_SRC - 1; i >= 0; i--)
      if (cand_hi[i]) begin
        found = 1'b1;
        idx   = VW'(i);
        hi    = 1'b1;
      end
  end
endmodule

// File: rtl/intc_lvl_stack.sv
module intc_lvl_stack
  import prio_intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic       push_hi,
  input  logic       pop,
  output logic [1:0] act
);
  always_ff @(posedge clk) begin
    if (rst) act <= 2'b00;
    else if (push) act[push_hi ? LV_HI : LV_LO] <= 1'b1;
    else if (pop) begin
      if (act[LV_HI]) act[LV_HI] <= 1'b0;
      else act[LV_LO] <= 1'b0;
    end
  end

  p_push_lo_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (push && !push_hi) |-> (act == 2'b00));
  p_push_hi_free_r8: assert property (@(posedge clk) disable iff (rst)
    push |-> !act[LV_HI]);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int N_HW  = N_HW_P,
  parameter int N_PIN = N_PIN_P,
  parameter int N_EVT = N_EVT_P,
  parameter int N_LVL = N_LVL_P,
  parameter int SYNC  = SYNC_P,
  localparam int N_SW  = N_PIN + N_EVT,
  localparam int N_SRC = N_HW + N_SW + N_LVL,
  localparam int VW    = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_HW-1:0]  hw_set,
  input  logic [N_PIN-1:0] pin_raw,
  input  logic [N_PIN-1:0] pin_pol,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [N_LVL-1:0] lvl_req,
  input  logic [N_SW-1:0]  sw_clr,
  input  logic             en_global,
  input  logic [N_SRC-1:0] en_src,
  input  logic [N_SRC-1:0] prio_hi,
  input  logic             irq_ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VW-1:0]    irq_vec,
  output logic             irq_hi,
  output logic [1:0]       act_lvl,
  output logic [N_SRC-1:0] pend
);
  logic            take;
  logic [N_HW-1:0] hw_clr;
  logic            found, pick_hi;
  logic [VW-1:0]   pick_idx;

  assign take = irq_ack && irq_req;

  genvar g;
  generate
    for (g = 0; g < N_HW; g++) begin : g_hwclr
      assign hw_clr[g] = take && (irq_vec == VW'(g));
    end
  endgenerate

  intc_src_flags #(.N_HW(N_HW), .N_PIN(N_PIN), .N_EVT(N_EVT),
                   .N_LVL(N_LVL), .SYNC(SYNC)) u_flags (
    .clk(clk), .rst(rst), .hw_set(hw_set), .hw_clr(hw_clr),
    .pin_raw(pin_raw), .pin_pol(pin_pol), .evt_in(evt_in),
    .lvl_in(lvl_req), .sw_clr(sw_clr), .pend(pend));

  intc_pick #(.N_SRC(N_SRC)) u_pick (
    .pend(pend), .en_src(en_src), .prio_hi(prio_hi), .en_global(en_global),
    .allow_hi(!act_lvl[LV_HI]), .allow_lo(act_lvl == 2'b00),
    .found(found), .idx(pick_idx), .hi(pick_hi));

  intc_lvl_stack u_stack (
    .clk(clk), .rst(rst), .push(take), .push_hi(irq_hi),
    .pop(reti), .act(act_lvl));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_hi  <= 1'b0;
    end else if (irq_req) begin
      if (irq_ack) irq_req <= 1'b0;
    end else if (found) begin
      irq_req <= 1'b1;
      irq_vec <= pick_idx;
      irq_hi  <= pick_hi;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec) && $stable(irq_hi)));
  p_drop_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> !irq_req);
  p_none_in_hi_r8: assert property (@(posedge clk) disable iff (rst)
    act_lvl[LV_HI] |-> !irq_req);
  p_lo_needs_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_hi) |-> (act_lvl == 2'b00));
  p_gate_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(en_global));
  p_stray_ack_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !irq_req && !reti) |=> $stable(act_lvl));
endmodule

// File: tb/prio_intc_bench.sv
`timescale 1ns/1ps
module prio_intc_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0]  hw_set = '0;
  logic [4:0]  pins = '0, pol = 5'b11111;
  logic [3:0]  evt = '0;
  logic [1:0]  lvl = '0;
  logic [8:0]  swclr = '0;
  logic        en_g = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [14:0] en_s = '0, pr = '0;
  logic        irq_req, irq_hi;
  logic [3:0]  irq_vec;
  logic [1:0]  act_lvl;
  logic [14:0] pend;

  prio_intc u_prio_intc (
    .clk(clk), .rst(rst), .hw_set(hw_set), .pin_raw(pins), .pin_pol(pol),
    .evt_in(evt), .lvl_req(lvl), .sw_clr(swclr), .en_global(en_g),
    .en_src(en_s), .prio_hi(pr), .irq_ack(ack), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_hi(irq_hi),
    .act_lvl(act_lvl), .pend(pend));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [3:0] m_hw;  logic [4:0] m_pin, m_s1, m_s2;
  logic [3:0] m_evt; logic [1:0] m_lvl, m_act;
  logic m_req, m_hi; int m_vec;

  always @(posedge clk) begin
    if (rst) begin
      m_hw = '0; m_pin = '0; m_s1 = '0; m_s2 = '0; m_evt = '0; m_lvl = '0;
      m_act = '0; m_req = 0; m_hi = 0; m_vec = 0;
    end else begin
      automatic logic [14:0] p = {m_lvl, m_evt, m_pin, m_hw};
      automatic logic [1:0] oa = m_act;
      automatic bit took = ack && m_req;
      automatic int best = -1;
      automatic bit bh = 0;
      for (int i = 0; i < 4; i++)
        if (hw_set[i]) m_hw[i] = 1;
        else if (took && m_vec == i) m_hw[i] = 0;
      for (int i = 0; i < 5; i++)
        m_pin[i] = swclr[i] ? 1'b0 : (m_pin[i] | (m_s2[i] == pol[i]));
      m_s2 = m_s1; m_s1 = pins;
      for (int i = 0; i < 4; i++)
        m_evt[i] = swclr[5+i] ? 1'b0 : (m_evt[i] | evt[i]);
      m_lvl = lvl;
      if (took) begin
        if (m_hi) m_act[1] = 1; else m_act[0] = 1;
      end else if (reti) begin
        if (m_act[1]) m_act[1] = 0; else m_act[0] = 0;
      end
      if (m_req) begin
        if (ack) m_req = 0;
      end else begin
        if (en_g && !oa[1])
          for (int i = 0; i < 15; i++)
            if (best < 0 && p[i] && en_s[i] && pr[i]) begin best = i; bh = 1; end
        if (en_g && oa == 2'b00)
          for (int i = 0; i < 15; i++)
            if (best < 0 && p[i] && en_s[i] && !pr[i]) best = i;
        if (best >= 0) begin m_req = 1; m_vec = best; m_hi = bh; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 pend", pend, {m_lvl, m_evt, m_pin, m_hw});
      chk("R7 req", irq_req, m_req);
      chk("R6 vec", irq_vec, m_vec);
      chk("R6 hi", irq_hi, m_hi);
      chk("R8 act", act_lvl, m_act);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_req(string req, int exp_vec, int exp_hi);
    int n = 0;
    while (!irq_req && n < 40) begin @(negedge clk); n++; end
    chk({req, " raised"}, irq_req, 1);
    chk({req, " index"}, irq_vec, exp_vec);
    chk({req, " level"}, irq_hi, exp_hi);
  endtask

  task automatic do_ack();
    ack = 1; cyc(1); ack = 0; cyc(1);
  endtask
  task automatic do_reti();
    reti = 1; cyc(1); reti = 0; cyc(1);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk); wd++;
      if (wd > 20000) begin
        bad++; total++;
        $display("FAIL watchdog: got %0d expected 0", wd);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    cyc(3);
    // R1: reset state
    chk("R1 req", irq_req, 0); chk("R1 vec", irq_vec, 0);
    chk("R1 hi", irq_hi, 0); chk("R1 act", act_lvl, 0); chk("R1 pend", pend, 0);
    rst = 0;
    cyc(1);
    chk("R1 post req", irq_req, 0); chk("R1 post pend", pend, 0);
    en_g = 1; en_s = '1;

    // R6/R4: two edge flags, index order; R7 hold without ack
    hw_set = 4'b1001; cyc(1); hw_set = '0;
    wait_req("R6 order", 0, 0);
    cyc(3);
    chk("R7 held vec", irq_vec, 0);
    do_ack();
    chk("R4 hw cleared", pend[0], 0);
    chk("R4 other kept", pend[3], 1);
    cyc(3);
    chk("R8 lo blocks lo", irq_req, 0);
    do_reti();
    wait_req("R6 next", 3, 0);
    do_ack(); do_reti();

    // R6: level beats index
    pr[3] = 1;
    hw_set = 4'b1001; cyc(1); hw_set = '0;
    wait_req("R6 level", 3, 1);
    do_ack(); do_reti();
    wait_req("R6 rest", 0, 0);
    do_ack(); do_reti();
    pr = '0;

    // R2: active-high pin, R3 clear while active
    pins[2] = 1;
    wait_req("R2 pin high", 6, 0);
    do_ack();
    swclr[2] = 1; cyc(1); swclr[2] = 0;
    chk("R3 dropped", pend[6], 0);
    cyc(1);
    chk("R3 reset again", pend[6], 1);
    pins[2] = 0; cyc(3);
    swclr[2] = 1; cyc(1); swclr[2] = 0; cyc(2);
    chk("R3 stays clear", pend[6], 0);
    do_reti();
    // R2: active-low pin
    pol[1] = 0;
    wait_req("R2 pin low", 5, 0);
    do_ack();
    pol[1] = 1; cyc(3);
    swclr[1] = 1; cyc(1); swclr[1] = 0;
    do_reti(); cyc(3);
    chk("R2 idle", irq_req, 0);

    // R5: masking
    en_g = 0;
    evt[0] = 1; cyc(1); evt[0] = 0; cyc(8);
    chk("R5 global off", irq_req, 0);
    chk("R3 event latched", pend[9], 1);
    en_s[9] = 0; en_g = 1; cyc(8);
    chk("R5 source off", irq_req, 0);
    en_s = '1;
    wait_req("R5 enabled", 9, 0);
    do_ack();
    swclr[5] = 1; cyc(1); swclr[5] = 0;
    do_reti();

    // R8: nesting, R4 level sources
    pr[13] = 1;
    lvl = 2'b10;
    wait_req("R4 level src", 14, 0);
    do_ack();
    lvl = 2'b00;
    chk("R8 lo in service", act_lvl, 1);
    hw_set[1] = 1; cyc(1); hw_set[1] = 0; cyc(4);
    chk("R8 lo waits", irq_req, 0);
    lvl = 2'b01;
    wait_req("R8 preempt", 13, 1);
    do_ack();
    lvl = 2'b00;
    chk("R8 both", act_lvl, 3);
    cyc(4);
    chk("R8 none in hi", irq_req, 0);
    do_reti();
    chk("R8 pop hi", act_lvl, 1);
    cyc(3);
    chk("R8 still blocked", irq_req, 0);
    do_reti();
    chk("R8 pop lo", act_lvl, 0);
    wait_req("R8 unwound", 1, 0);
    do_ack(); do_reti();
    cyc(3);

    // R9: stray acknowledge
    ack = 1; cyc(1); ack = 0; cyc(2);
    chk("R9 act", act_lvl, 0);
    chk("R9 req", irq_req, 0);

    cyc(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule